// File: doc/BRIEF.md
# Calendar Register Access Window

This block gives a 16-bit bus a narrow view onto two small banks of calendar registers. One bank holds timekeeping bytes and the other holds alarm bytes. Each bank is seen through a single 16-bit window split into a high byte and a low byte. A 2-bit pointer, held in a per-bank pointer register, picks which byte pair currently shows in that window.

Every read of a window moves that bank's pointer down by one. So does every write that touches the window's high byte. Software can therefore load the pointer once and then walk the whole bank with a string of accesses. The pointer saturates at zero and stays there until software loads a new value.

The stored bytes are driven out as flat vectors for the neighbouring counter and compare logic. Permission to write the timekeeping bank arrives on an input pin.

Top module: `cal_reg_window`

## Requirements
- R1: After a synchronous active-high reset, both pointers, every stored byte, `time_regs`, `alarm_regs` and `bus_rdata` are zero.
- R2: A write to address 2 (time pointer) or address 3 (alarm pointer) with `bus_be[0]` set loads `bus_wdata[1:0]` into that pointer. Reading the same address returns the pointer in bits [1:0] and zero elsewhere. Such a read does not change the pointer.
- R3: The time window at address 0 maps pointer values to byte pairs as follows (high byte:low byte):
  - 0: minutes:seconds
  - 1: weekday:hours
  - 2: month:day
  - 3: reserved:year

  In `time_regs`, the byte at pointer p and half h (h=1 for high) sits at bits [(2p+h)*8 +: 8].
- R4: The alarm window at address 1 maps pointer values as follows:
  - 0: alarm minutes:alarm seconds
  - 1: alarm weekday:alarm hours
  - 2: alarm month:alarm day
  - 3: both bytes reserved

  `alarm_regs` uses the same bit placement as R3.
- R5: A window write with `bus_be[1]` set lowers that bank's pointer by one. At zero the pointer stays at zero. This holds even when the write itself is blocked.
- R6: A window write with only `bus_be[0]` set leaves the pointer unchanged.
- R7: A window read returns, one cycle later on `bus_rdata`, the pair the pointer selected when the read was issued. It then lowers the pointer by one, saturating at zero.
- R8: Writes to the time window change stored bytes only while `time_wr_allow` is high. Alarm window writes and pointer loads do not depend on it.
- R9: Reserved bytes always read as zero and appear as zero on `time_regs`/`alarm_regs`. Writes to them are discarded.
- R10: `bus_rdata` changes only in the cycle after a read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Target: 0 time window, 1 alarm window, 2 time pointer, 3 alarm pointer |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_be | input | 2 | Byte enables for writes: bit 1 high byte, bit 0 low byte |
| bus_wdata | input | 16 | Write data |
| time_wr_allow | input | 1 | Permission to modify timekeeping bytes |
| bus_rdata | output | 16 | Registered read data |
| time_regs | output | 64 | Stored timekeeping bytes, placement per R3 |
| alarm_regs | output | 64 | Stored alarm bytes, placement per R4 |

## Verification
The properties assume that `bus_rd` and `bus_wr` are never raised together. This lets a pointer move be tied to exactly one kind of access. The bench keeps every access a one-cycle strobe of a single kind and leaves an idle cycle between accesses. It sweeps every pointer value, byte-enable pattern and permission level on both windows. A byte-level model in the bench predicts stored contents, read data and pointer position.

// File: rtl/calwin_pkg.sv
package calwin_pkg;
  localparam int DATA_W = 16;
  localparam int PTR_W  = 2;

  typedef enum logic [1:0] {
    TGT_TIME_WIN = 2'd0,
    TGT_ALRM_WIN = 2'd1,
    TGT_TIME_PTR = 2'd2,
    TGT_ALRM_PTR = 2'd3
  } bus_tgt_e;
endpackage

// File: rtl/calwin_ptr.sv
module calwin_ptr #(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_load,
  input  logic [PTR_W-1:0] sw_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr_q
);
  // software load has priority over the access-driven step
  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= '0;
    else if (sw_load)
      ptr_q <= sw_val;
    else if (step && (ptr_q != '0))
      ptr_q <= ptr_q - 1'b1;
  end
endmodule

// File: rtl/calwin_bank.sv
module calwin_bank #(
  parameter int BYTE_W = 8,
  parameter int PTR_W  = 2,
  parameter logic [(2<<PTR_W)-1:0] BYTE_VALID = '1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr,
  input  logic [1:0]                        be,
  input  logic [2*BYTE_W-1:0]               wdata,
  input  logic [PTR_W-1:0]                  ptr,
  output logic [2*BYTE_W-1:0]               rd_word,
  output logic [(2<<PTR_W)*BYTE_W-1:0]      regs_o
);
  localparam int SLOTS  = 1 << PTR_W;
  localparam int NBYTES = 2 * SLOTS;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    if (BYTE_VALID[g]) begin : g_live
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (wr && be[g%2] && (ptr == PTR_W'(g/2)))
          q <= wdata[(g%2)*BYTE_W +: BYTE_W];
      end
      assign regs_o[g*BYTE_W +: BYTE_W] = q;
    end else begin : g_resv
      assign regs_o[g*BYTE_W +: BYTE_W] = '0;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < SLOTS; i++)
      if (ptr == PTR_W'(i))
        rd_word = regs_o[i*2*BYTE_W +: 2*BYTE_W];
  end
endmodule

// File: rtl/cal_reg_window.sv
module cal_reg_window
  import calwin_pkg::*;
#(
  parameter int DW = calwin_pkg::DATA_W,
  parameter int PW = calwin_pkg::PTR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [1:0]             bus_be,
  input  logic [DW-1:0]          bus_wdata,
  input  logic                   time_wr_allow,
  output logic [DW-1:0]          bus_rdata,
  output logic [DW*(1<<PW)-1:0]  time_regs,
  output logic [DW*(1<<PW)-1:0]  alarm_regs
);
  localparam int BYTE_W = DW / 2;
  localparam int SLOTS  = 1 << PW;
  localparam int REG_W  = DW * SLOTS;
  localparam int NBYTES = 2 * SLOTS;
  // top slot high byte reserved in the time bank, whole top slot in the alarm bank
  localparam logic [NBYTES-1:0] TIME_VALID = {1'b0, {(NBYTES-1){1'b1}}};
  localparam logic [NBYTES-1:0] ALRM_VALID = {2'b00, {(NBYTES-2){1'b1}}};

  logic [PW-1:0]    win_ptr  [2];
  logic [DW-1:0]    win_word [2];
  logic [REG_W-1:0] win_regs [2];

  for (genvar w = 0; w < 2; w++) begin : g_win
    logic win_hit, cfg_hit, bank_wr, wr_ok;
    assign win_hit = (bus_addr == 2'(w));
    assign cfg_hit = (bus_addr == 2'(w + 2));
    assign wr_ok   = (w != 0) || time_wr_allow;
    assign bank_wr = bus_wr && win_hit && wr_ok;

    calwin_ptr #(.PTR_W(PW)) u_ptr (
      .clk     (clk),
      .rst     (rst),
      .sw_load (bus_wr && cfg_hit && bus_be[0]),
      .sw_val  (bus_wdata[PW-1:0]),
      .step    (win_hit && (bus_rd || (bus_wr && bus_be[1]))),
      .ptr_q   (win_ptr[w])
    );

    calwin_bank #(
      .BYTE_W     (BYTE_W),
      .PTR_W      (PW),
      .BYTE_VALID ((w == 0) ? TIME_VALID : ALRM_VALID)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr      (bank_wr),
      .be      (bus_be),
      .wdata   (bus_wdata),
      .ptr     (win_ptr[w]),
      .rd_word (win_word[w]),
      .regs_o  (win_regs[w])
    );
  end

  assign time_regs  = win_regs[0];
  assign alarm_regs = win_regs[1];

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_tgt_e'(bus_addr))
        TGT_TIME_WIN: bus_rdata <= win_word[0];
        TGT_ALRM_WIN: bus_rdata <= win_word[1];
        TGT_TIME_PTR: bus_rdata <= DW'(win_ptr[0]);
        default:      bus_rdata <= DW'(win_ptr[1]);
      endcase
    end
  end
endmodule

// File: rtl/cal_reg_window_chk.sv
module cal_reg_window_chk #(
  parameter int DW    = 16,
  parameter int PW    = 2,
  parameter int REG_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [1:0]       bus_be,
  input logic             time_wr_allow,
  input logic [DW-1:0]    bus_rdata,
  input logic [REG_W-1:0] time_regs,
  input logic [REG_W-1:0] alarm_regs,
  input logic [PW-1:0]    tptr,
  input logic [PW-1:0]    aptr
);
  localparam int BYTE_W = DW / 2;

  p_hi_wr_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == 2'd0 && bus_be[1] && tptr != '0)
      |=> (tptr == $past(tptr) - 1'b1));

  p_hi_wr_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == 2'd0 && bus_be[1] && tptr == '0)
      |=> (tptr == '0));

  p_lo_wr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == 2'd0 && bus_be == 2'b01)
      |=> $stable(tptr));

  p_rd_dec_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == 2'd1 && aptr != '0)
      |=> (aptr == $past(aptr) - 1'b1));

  p_wr_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !time_wr_allow |=> $stable(time_regs));

  p_resv_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (time_regs[REG_W-1 -: BYTE_W] == '0) && (alarm_regs[REG_W-1 -: 2*BYTE_W] == '0));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind cal_reg_window cal_reg_window_chk #(.DW(DW), .PW(PW), .REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_be        (bus_be),
  .time_wr_allow (time_wr_allow),
  .bus_rdata     (bus_rdata),
  .time_regs     (time_regs),
  .alarm_regs    (alarm_regs),
  .tptr          (win_ptr[0]),
  .aptr          (win_ptr[1])
);

// File: tb/cal_reg_window_tb.sv
module cal_reg_window_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic        time_wr_allow = 1'b0;
  logic [15:0] bus_rdata;
  logic [63:0] time_regs, alarm_regs;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] mem [2][8];
  logic [1:0] mptr [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_reg_window u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .time_wr_allow(time_wr_allow),
    .bus_rdata(bus_rdata), .time_regs(time_regs), .alarm_regs(alarm_regs)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic bit byte_ok(input int w, input int b);
    return (w == 0) ? (b != 7) : (b < 6);
  endfunction

  function automatic logic [63:0] model_flat(input int w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = mem[w][b];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1: watchdog expired, actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, held;
    logic [7:0] hi, lo;
    int k;
    string tg;
    for (int w = 0; w < 2; w++) begin
      mptr[w] = '0;
      for (int b = 0; b < 8; b++) mem[w][b] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", {48'd0, bus_rdata}, 64'd0);
    chk("R1", time_regs, 64'd0);
    chk("R1", alarm_regs, 64'd0);
    bus_read(2'd2, rd); chk("R1", {48'd0, rd}, 64'd0);
    bus_read(2'd3, rd); chk("R1", {48'd0, rd}, 64'd0);

    k = 0;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++)
        for (int be = 1; be < 4; be++)
          for (int al = 0; al < 2; al++) begin
            k++;
            time_wr_allow = al[0];
            // R2: load pointer, read back twice
            bus_write(2'(w + 2), 2'b01, 16'hFFFC | 16'(s));
            mptr[w] = 2'(s);
            bus_read(2'(w + 2), rd); chk("R2", {48'd0, rd}, {62'd0, mptr[w]});
            bus_read(2'(w + 2), rd); chk("R2", {48'd0, rd}, {62'd0, mptr[w]});

            hi = 8'(k * 7 + 3);
            lo = 8'(k * 13 + 5);
            bus_write(2'(w), 2'(be), {hi, lo});
            if (w == 1 || al == 1) begin
              if (be[0] && byte_ok(w, 2*s))     mem[w][2*s]     = lo;
              if (be[1] && byte_ok(w, 2*s + 1)) mem[w][2*s + 1] = hi;
            end
            if (be[1] && mptr[w] != 2'd0) mptr[w] = mptr[w] - 2'd1;
            tg = (w == 0 && al == 0) ? "R8" : (s == 3 ? "R9" : (w == 0 ? "R3" : "R4"));
            chk(tg, (w == 0) ? time_regs : alarm_regs, model_flat(w));
            bus_read(2'(w + 2), rd);
            chk(be[1] ? "R5" : "R6", {48'd0, rd}, {62'd0, mptr[w]});

            // R7: window read returns the selected pair, then steps down
            bus_write(2'(w + 2), 2'b01, 16'(s));
            mptr[w] = 2'(s);
            bus_read(2'(w), rd);
            tg = (s == 3) ? "R9" : (w == 0 ? "R3" : "R4");
            chk(tg, {48'd0, rd}, {48'd0, mem[w][2*s + 1], mem[w][2*s]});
            held = rd;
            @(negedge clk);
            chk("R10", {48'd0, bus_rdata}, {48'd0, held});
            if (mptr[w] != 2'd0) mptr[w] = mptr[w] - 2'd1;
            bus_read(2'(w + 2), rd);
            chk("R7", {48'd0, rd}, {62'd0, mptr[w]});
          end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule